// File: doc/BRIEF.md
# Nested Interrupt Priority Arbiter

This block is the decision core of a nested vectored interrupt controller. It latches requests from system exception sources (exception numbers 1 to 15) and from external interrupt lines (numbers 16 and up) into per-source pending bits. It holds a programmable priority byte for each source. A runtime group field splits every priority byte into a preempt part and a sub part. From these it chooses which exception to enter, and it reports that choice as a one-cycle take strobe with the exception number.

The arbiter keeps a stack of entered exceptions together with their preempt levels. A pending exception enters only if its preempt level is strictly more urgent than the level currently running. An exception-return input pops the stack. In that same cycle the arbiter re-evaluates the pending sources against the level below.

Three sources have fixed priorities above every programmable one: system reset (1), non-maskable interrupt (2) and hard fault (3). A supervisor-call request that could not enter at once is turned into a hard fault. The deferred service call (14) is pended by a register write. The usage fault (6) is raised when software tries to return to thread level while other exceptions are still active.

Top module: `irq_prio_arb`

## Requirements
- R1: A request bit `src_req_i[n]` that is high for a single cycle is latched into pending bit n. It is taken later even though the line has dropped. Bit 0 never pends.
- R2: The priority byte of exception n (4 <= n < 16+NUM_IRQ) is at register address n. Only its upper PRIO_BITS bits are stored, and the lower bits read as zero. Addresses 1 to 3 read as zero whatever was written.
- R3: Among pending exceptions, the numerically smallest full priority byte wins. When full priorities are equal, the lowest exception number wins.
- R4: The group field is bits [2:0] at address 16+NUM_IRQ. With group value g, bits [g:0] of a priority are the sub part and bits [7:g+1] are the preempt part. An exception enters over a running one only if its preempt part is strictly smaller.
- R5: Among pending exceptions with equal preempt parts, the smaller sub part is taken first.
- R6: Exceptions 1, 2 and 3 rank above all programmable priorities, in that order (1 most urgent). Each always preempts programmable exceptions.
- R7: A supervisor-call request (exception 11) whose preempt level is not strictly above the running level sets the hard-fault pending bit (3) instead of its own.
- R8: Writing 1 to bit 0 of address 17+NUM_IRQ pends exception 14. This bit reads back as its pending state, and the exception waits until its level permits entry.
- R9: Taking an exception clears its pending bit, marks it active and pushes it. `act_num_o` shows the top active number, or 0 at thread level.
- R10: When `ret_i` is high, the top entry is popped, and pending sources are compared against the level below in the same cycle.
- R11: A return with `ret_thread_i` high while more than one exception is active sets the usage-fault pending bit (6).
- R12: `take_o` is a registered one-cycle strobe. A request sampled at one clock edge produces `take_o` after the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_req_i | input | 16+NUM_IRQ | Request per exception number |
| ret_i | input | 1 | Exception return: pop active level |
| ret_thread_i | input | 1 | Return targets thread level |
| wr_en_i | input | 1 | Register write enable |
| addr_i | input | AW | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data (combinational) |
| take_o | output | 1 | Exception entry strobe |
| take_num_o | output | NW | Number of the exception entered |
| act_num_o | output | NW | Top active exception number, 0 at thread |

## Verification
An exception return and the entry of a new exception can fall in the same cycle. The pop lowers the running level, and a waiting source then wins against the level beneath it. The bench provokes this by parking a less urgent request under an active one, or by pending the deferred service call under an active one, and then pulsing `ret_i`. It judges the cycle by expecting `take_o` and the new number on `act_num_o` right after the return edge, with no idle cycle between them.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int unsigned EXC_RESET = 1;
  localparam int unsigned EXC_NMI   = 2;
  localparam int unsigned EXC_HARD  = 3;
  localparam int unsigned EXC_USAGE = 6;
  localparam int unsigned EXC_SVC   = 11;
  localparam int unsigned EXC_PSV   = 14;
  localparam int unsigned NUM_SYS   = 16;
  localparam int unsigned LVL_W     = 11;
  localparam logic [LVL_W-1:0] LVL_THREAD = 11'h400;

  typedef logic [LVL_W-1:0] lvl_t;

  // preempt mask for group g: bits [g:0] are sub priority
  function automatic logic [7:0] grp_mask(input logic [2:0] grp);
    logic [8:0] m;
    m = 9'h1fe << grp;
    return m[7:0];
  endfunction

  // urgency key: fixed sources first, then programmable byte
  function automatic lvl_t prio_key(input int unsigned num, input logic [7:0] prio,
                                    input logic [7:0] mask);
    logic [1:0] cls;
    if (num < 4) begin
      cls = 2'(num - 1);
      return {1'b0, cls, 8'h00};
    end
    return {1'b0, 2'b11, prio & mask};
  endfunction
endpackage

// File: rtl/irq_prio_regs.sv
module irq_prio_regs #(
  parameter int unsigned NSRC      = 24,
  parameter int unsigned PRIO_BITS = 3,
  parameter int unsigned AW        = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [7:0]           wdata_i,
  input  logic                 psv_pend_i,
  output logic [7:0]           rdata_o,
  output logic [NSRC-1:0][7:0] prio_o,
  output logic [2:0]           grp_o,
  output logic                 psv_set_o
);
  localparam logic [7:0] IMPL_MASK = 8'(8'hff << (8 - PRIO_BITS));
  localparam int unsigned ADDR_GRP = NSRC;
  localparam int unsigned ADDR_PSV = NSRC + 1;

  logic [2:0] grp_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_prio
    if (i < 4) begin : g_fixed
      assign prio_o[i] = 8'h00;
    end else begin : g_prog
      logic [7:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= 8'h00;
        else if (wr_en_i && addr_i == AW'(i)) q <= wdata_i & IMPL_MASK;
      end
      assign prio_o[i] = q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) grp_q <= 3'd0;
    else if (wr_en_i && addr_i == AW'(ADDR_GRP)) grp_q <= wdata_i[2:0];
  end

  assign grp_o     = grp_q;
  assign psv_set_o = wr_en_i && addr_i == AW'(ADDR_PSV) && wdata_i[0];

  always_comb begin
    rdata_o = 8'h00;
    if (int'(addr_i) < NSRC)          rdata_o = prio_o[addr_i];
    else if (addr_i == AW'(ADDR_GRP)) rdata_o = {5'd0, grp_q};
    else if (addr_i == AW'(ADDR_PSV)) rdata_o = {7'd0, psv_pend_i};
  end
endmodule

// File: rtl/irq_sel.sv
module irq_sel
  import irq_arb_pkg::*;
#(
  parameter int unsigned NSRC = 24,
  parameter int unsigned NW   = 5
) (
  input  logic [NSRC-1:0]      pend_i,
  input  logic [NSRC-1:0][7:0] prio_i,
  input  logic [2:0]           grp_i,
  output logic                 vld_o,
  output logic [NW-1:0]        num_o,
  output lvl_t                 pk_o
);
  lvl_t best;
  lvl_t k;

  always_comb begin
    vld_o = 1'b0;
    num_o = '0;
    best  = '1;
    for (int i = 0; i < NSRC; i++) begin
      k = prio_key(i, prio_i[i], 8'hff);
      if (pend_i[i] && (!vld_o || k < best)) begin
        vld_o = 1'b1;
        best  = k;
        num_o = NW'(i);
      end
    end
    pk_o = prio_key(int'(num_o), prio_i[num_o], grp_mask(grp_i));
  end
endmodule

// File: rtl/irq_act_stack.sv
module irq_act_stack
  import irq_arb_pkg::*;
#(
  parameter int unsigned DEPTH = 11,
  parameter int unsigned NW    = 5,
  parameter int unsigned DW    = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [NW-1:0] push_num_i,
  input  lvl_t          push_lvl_i,
  output logic [NW-1:0] top_num_o,
  output lvl_t          top_lvl_o,
  output lvl_t          below_lvl_o,
  output logic [DW-1:0] depth_o,
  output logic          full_o
);
  localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [NW-1:0] num_q [DEPTH];
  lvl_t          lvl_q [DEPTH];
  logic [DW-1:0] depth_q;
  logic [IW-1:0] top_idx, below_idx, wr_idx;

  assign top_idx   = IW'(depth_q - DW'(1));
  assign below_idx = IW'(depth_q - DW'(2));
  assign wr_idx    = IW'(depth_q - DW'(pop_i));

  assign top_num_o   = (depth_q == '0) ? '0 : num_q[top_idx];
  assign top_lvl_o   = (depth_q == '0) ? LVL_THREAD : lvl_q[top_idx];
  assign below_lvl_o = (depth_q < DW'(2)) ? LVL_THREAD : lvl_q[below_idx];
  assign depth_o     = depth_q;
  assign full_o      = depth_q == DW'(DEPTH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) depth_q <= '0;
    else depth_q <= depth_q - DW'(pop_i) + DW'(push_i);
  end

  always_ff @(posedge clk_i) begin
    if (push_i) begin
      num_q[wr_idx] <= push_num_i;
      lvl_q[wr_idx] <= push_lvl_i;
    end
  end
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
  import irq_arb_pkg::*;
#(
  parameter int unsigned NUM_IRQ   = 8,
  parameter int unsigned PRIO_BITS = 3,
  localparam int unsigned NSRC     = NUM_SYS + NUM_IRQ,
  localparam int unsigned AW       = $clog2(NSRC + 2),
  localparam int unsigned NW       = $clog2(NSRC)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] src_req_i,
  input  logic            ret_i,
  input  logic            ret_thread_i,
  input  logic            wr_en_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [7:0]      wdata_i,
  output logic [7:0]      rdata_o,
  output logic            take_o,
  output logic [NW-1:0]   take_num_o,
  output logic [NW-1:0]   act_num_o
);
  localparam int unsigned STACK_DEPTH = 3 + (1 << PRIO_BITS);
  localparam int unsigned DW = $clog2(STACK_DEPTH + 1);

  logic [NSRC-1:0]      pend_q, pend_d, act_q, act_d;
  logic [NSRC-1:0][7:0] prio;
  logic [2:0]           grp;
  logic                 psv_set;
  logic                 win_vld;
  logic [NW-1:0]        win_num, top_num;
  lvl_t                 win_pk, top_lvl, below_lvl, cur_lvl, svc_pk;
  logic [DW-1:0]        depth;
  logic                 full, pop, go, uf_set;

  irq_prio_regs #(.NSRC(NSRC), .PRIO_BITS(PRIO_BITS), .AW(AW)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .psv_pend_i(pend_q[EXC_PSV]), .rdata_o, .prio_o(prio), .grp_o(grp),
    .psv_set_o(psv_set)
  );

  irq_sel #(.NSRC(NSRC), .NW(NW)) u_sel (
    .pend_i(pend_q), .prio_i(prio), .grp_i(grp),
    .vld_o(win_vld), .num_o(win_num), .pk_o(win_pk)
  );

  irq_act_stack #(.DEPTH(STACK_DEPTH), .NW(NW), .DW(DW)) u_stack (
    .clk_i, .rst_ni, .push_i(go), .pop_i(pop), .push_num_i(win_num),
    .push_lvl_i(win_pk), .top_num_o(top_num), .top_lvl_o(top_lvl),
    .below_lvl_o(below_lvl), .depth_o(depth), .full_o(full)
  );

  assign pop     = ret_i && depth != '0;
  assign cur_lvl = pop ? below_lvl : top_lvl;
  assign go      = win_vld && win_pk < cur_lvl && (!full || pop);
  assign uf_set  = pop && ret_thread_i && depth > DW'(1);
  assign svc_pk  = prio_key(EXC_SVC, prio[EXC_SVC], grp_mask(grp));

  always_comb begin
    pend_d = pend_q;
    if (go) pend_d[win_num] = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (src_req_i[i] && i != EXC_SVC) pend_d[i] = 1'b1;
    end
    if (src_req_i[EXC_SVC]) begin
      if (svc_pk < cur_lvl) pend_d[EXC_SVC]  = 1'b1;
      else                  pend_d[EXC_HARD] = 1'b1;
    end
    if (psv_set) pend_d[EXC_PSV]   = 1'b1;
    if (uf_set)  pend_d[EXC_USAGE] = 1'b1;
    pend_d[0] = 1'b0;
  end

  always_comb begin
    act_d = act_q;
    if (pop) act_d[top_num] = 1'b0;
    if (go)  act_d[win_num] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= '0;
      act_q      <= '0;
      take_o     <= 1'b0;
      take_num_o <= '0;
    end else begin
      pend_q     <= pend_d;
      act_q      <= act_d;
      take_o     <= go;
      take_num_o <= go ? win_num : take_num_o;
    end
  end

  assign act_num_o = top_num;
endmodule

// File: rtl/irq_prio_arb_chk.sv
module irq_prio_arb_chk #(
  parameter int unsigned NSRC  = 24,
  parameter int unsigned NW    = 5,
  parameter int unsigned DW    = 4,
  parameter int unsigned DEPTH = 11
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            take_i,
  input logic [NW-1:0]   take_num_i,
  input logic [NW-1:0]   act_num_i,
  input logic            ret_i,
  input logic [NSRC-1:0] pend_i,
  input logic [NSRC-1:0] act_i,
  input logic [DW-1:0]   depth_i
);
  assert_take_on_top_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> act_num_i == take_num_i);

  assert_take_active_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> act_i[take_num_i]);

  assert_active_count_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(act_i) == int'(depth_i));

  assert_thread_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depth_i == '0 |-> act_num_i == '0);

  assert_ret_pops_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && depth_i != '0) |=> depth_i <= $past(depth_i));

  assert_no_pend_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_i[0]);

  assert_depth_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(depth_i) <= DEPTH);
endmodule

bind irq_prio_arb irq_prio_arb_chk #(.NSRC(NSRC), .NW(NW), .DW(DW), .DEPTH(STACK_DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .take_i(take_o), .take_num_i(take_num_o),
  .act_num_i(act_num_o), .ret_i(ret_i), .pend_i(pend_q), .act_i(act_q),
  .depth_i(depth)
);

// File: tb/tb_irq_prio_arb.sv
`timescale 1ns/1ps
module tb_irq_prio_arb;
  localparam int NUM_IRQ = 8;
  localparam int NSRC = 16 + NUM_IRQ;
  localparam int AW = $clog2(NSRC + 2);
  localparam int NW = $clog2(NSRC);
  localparam int A_GRP = NSRC;
  localparam int A_PSV = NSRC + 1;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [NSRC-1:0] src_req = '0;
  logic ret = 1'b0, ret_thr = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic take;
  logic [NW-1:0] take_num, act_num;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_prio_arb #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(3)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .src_req_i(src_req), .ret_i(ret),
    .ret_thread_i(ret_thr), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .take_o(take), .take_num_o(take_num), .act_num_o(act_num)
  );

  task automatic chk(string tag, int actual, int expected);
    total++;
    if (actual != expected) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; src_req = '0; ret = 0; ret_thr = 0; wr_en = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    wr_en = 1; addr = AW'(a); wdata = 8'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd_chk(int a, int expected, string tag);
    addr = AW'(a);
    #1;
    chk(tag, int'(rdata), expected);
  endtask

  task automatic pulse(logic [NSRC-1:0] m);
    src_req = m;
    @(negedge clk);
    src_req = '0;
  endtask

  task automatic do_ret(bit thr);
    ret = 1; ret_thr = thr;
    @(negedge clk);
    ret = 0; ret_thr = 0;
  endtask

  task automatic see_take(int num, string tag);
    chk({tag, " take"}, int'(take), 1);
    chk({tag, " num"}, int'(take_num), num);
    chk({tag, " act"}, int'(act_num), num);
  endtask

  task automatic expect_take(int num, string tag);
    @(negedge clk);
    see_take(num, tag);
  endtask

  task automatic expect_idle(string tag);
    @(negedge clk);
    chk({tag, " idle"}, int'(take), 0);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R9 reset take", int'(take), 0);
    chk("R9 reset act", int'(act_num), 0);
    rd_chk(A_GRP, 0, "R4 reset grp");
    rd_chk(20, 0, "R2 reset prio");
  endtask

  task automatic t_regs();
    do_reset();
    wr(16, 8'hff); rd_chk(16, 8'he0, "R2 trunc ff");
    wr(17, 8'h7f); rd_chk(17, 8'h60, "R2 trunc 7f");
    wr(2, 8'hff);  rd_chk(2, 0, "R2 fixed ro");
    wr(A_GRP, 8'hfd); rd_chk(A_GRP, 5, "R4 grp rd");
  endtask

  task automatic t_latch();
    do_reset();
    pulse(NSRC'(1) << 16);
    chk("R12 not yet", int'(take), 0);
    expect_take(16, "R1 latched pulse");
    expect_idle("R12 one cycle");
    do_ret(0);
    chk("R10 back thread", int'(act_num), 0);
  endtask

  task automatic t_ret_same_cycle();
    do_reset();
    wr(16, 8'h40); wr(17, 8'h20);
    pulse((NSRC'(1) << 16) | (NSRC'(1) << 17));
    expect_take(17, "R3 smaller value");
    expect_idle("R4 no preempt lower");
    do_ret(0);
    see_take(16, "R10 same-cycle reentry");
  endtask

  task automatic t_tie();
    do_reset();
    wr(16, 8'h40); wr(17, 8'h40);
    pulse((NSRC'(1) << 16) | (NSRC'(1) << 17));
    expect_take(16, "R3 tie low number");
    expect_idle("R4 equal no preempt");
    do_ret(0);
    see_take(17, "R10 tie second");
  endtask

  task automatic t_group();
    do_reset();
    wr(A_GRP, 5); wr(16, 8'h20); wr(17, 8'h00);
    pulse((NSRC'(1) << 16) | (NSRC'(1) << 17));
    expect_take(17, "R5 sub order");
    do_ret(0);
    see_take(16, "R5 sub second");
    do_ret(0);
    pulse(NSRC'(1) << 16);
    expect_take(16, "R4 g5 first");
    pulse(NSRC'(1) << 17);
    expect_idle("R4 g5 same preempt");
    do_ret(0);
    see_take(17, "R4 g5 after ret");
    do_reset();
    wr(A_GRP, 4); wr(16, 8'h20); wr(17, 8'h00);
    pulse(NSRC'(1) << 16);
    expect_take(16, "R4 g4 first");
    pulse(NSRC'(1) << 17);
    expect_take(17, "R4 g4 preempts");
  endtask

  task automatic t_fixed();
    do_reset();
    pulse(NSRC'(1) << 16);
    expect_take(16, "R6 base");
    pulse(NSRC'(1) << 2);
    expect_take(2, "R6 nmi preempts");
    pulse(NSRC'(1) << 3);
    expect_idle("R6 hard below nmi");
    pulse(NSRC'(1) << 1);
    expect_take(1, "R6 reset over nmi");
    do_ret(0);
    chk("R6 hard waits", int'(take), 0);
    do_ret(0);
    see_take(3, "R6 hard over prog");
  endtask

  task automatic t_svc();
    do_reset();
    wr(11, 8'h80); wr(16, 8'h20);
    pulse(NSRC'(1) << 16);
    expect_take(16, "R7 base");
    pulse(NSRC'(1) << 11);
    expect_take(3, "R7 escalate");
    do_ret(0);
    do_ret(0);
    chk("R7 svc not pended a", int'(take), 0);
    expect_idle("R7 svc not pended b");
    pulse(NSRC'(1) << 11);
    expect_take(11, "R7 svc at thread");
  endtask

  task automatic t_psv();
    do_reset();
    wr(14, 8'he0); wr(16, 8'h20);
    pulse(NSRC'(1) << 16);
    expect_take(16, "R8 base");
    wr(A_PSV, 1);
    rd_chk(A_PSV, 1, "R8 pend rd");
    expect_idle("R8 waits");
    do_ret(0);
    see_take(14, "R8 enters");
    rd_chk(A_PSV, 0, "R9 pend cleared");
  endtask

  task automatic t_usage();
    do_reset();
    wr(16, 8'h40); wr(17, 8'h20);
    pulse(NSRC'(1) << 16);
    expect_take(16, "R11 base");
    pulse(NSRC'(1) << 17);
    expect_take(17, "R11 nest");
    do_ret(1);
    chk("R11 pop", int'(act_num), 16);
    expect_take(6, "R11 usage fault");
  endtask

  initial begin
    t_reset();
    t_regs();
    t_latch();
    t_ret_same_cycle();
    t_tie();
    t_group();
    t_fixed();
    t_svc();
    t_psv();
    t_usage();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule